// File: doc/BRIEF.md
# CAN Transmit Command and Status Controller

This block sits between the host CPU and an abstract CAN protocol engine. It accepts transmit-request and abort commands from the CPU. It tells the engine when a frame is waiting to go out. It tracks the engine's handshake strobes: frame start, successful completion, and the retry point after lost arbitration or an error. From all of this it keeps a read-only 8-bit status word up to date.

A request cannot be withdrawn by writing its bit back to zero; only an abort can cancel it. An abort cancels a request only while the frame has not yet started. An abort that arrives during a frame is held, so the frame still finishes normally, but a retry that would follow a failed attempt is suppressed.

Every return of the transmit buffer to the released state raises a one-cycle transmit interrupt, whether the frame succeeded, was aborted or was dropped by bus-off. CPU writes into the transmit buffer are gated off while it is locked. The block also compares both error counters against a programmable warning limit and reports bus-off and receive activity. Bit timing, framing, CRC, arbitration and counter updates belong elsewhere.

Top module: `can_txctl`

## Requirements
- R1: After reset the status word reads 8'h0C: bit 2 (buffer released) = 1, bit 3 (last transmission complete) = 1, all other bits 0. tx_irq and eng_go are both 0.
- R2: A command write with req = 1 and abort = 0, while the buffer is released and bus_off is 0, is accepted. From the next cycle status bit 2 = 0, bit 3 = 0 and eng_go = 1.
- R3: While a request is pending, a command write with req = 0 and abort = 0 has no effect: bit 2 stays 0 and eng_go stays 1.
- R4: An abort written while the request is pending and no frame has started cancels it. On the next cycle bit 2 = 1, bit 3 stays 0 and eng_go = 0.
- R5: A command write with both req = 1 and abort = 1 while released starts nothing: the status word and eng_go are unchanged.
- R6: eng_start moves a pending request to transmitting: status bit 5 = 1 and eng_go = 0. A later eng_done releases the buffer with bit 3 = 1 and bit 5 = 0.
- R7: An abort during a frame does not stop it. If the frame then completes, bit 3 = 1. If instead it reaches the retry point (eng_retry), the buffer is released with bit 3 = 0 and eng_go stays 0.
- R8: eng_retry with no abort pending returns the request to waiting: bit 5 = 0, bit 2 = 0, eng_go = 1.
- R9: tx_irq is a single-cycle pulse, high in exactly the first cycle in which status bit 2 reads 1 after reading 0. This includes releases caused by an abort or by bus-off.
- R10: Status bit 6 is 1 when tx_err_cnt >= warn_limit or rx_err_cnt >= warn_limit, and 0 otherwise. It is sampled one cycle after the inputs.
- R11: Status bit 7 follows bus_off and bit 4 follows rx_active, each one cycle late. Bits 1 and 0 always read 0.
- R12: While bus_off is 1, any pending or transmitting request is dropped (bit 2 = 1, bit 5 = 0, eng_go = 0) and new requests are ignored.
- R13: buf_we equals buf_wr while the buffer is released and is 0 while it is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_req | input | 1 | Transmit request bit of the command write |
| cmd_abort | input | 1 | Abort bit of the command write |
| eng_start | input | 1 | Engine: frame has started on the bus |
| eng_done | input | 1 | Engine: frame completed successfully |
| eng_retry | input | 1 | Engine: attempt failed, retry point reached |
| rx_active | input | 1 | A frame is being received |
| bus_off | input | 1 | Node is in bus-off state |
| tx_err_cnt | input | CNT_W | Transmit error counter |
| rx_err_cnt | input | CNT_W | Receive error counter |
| warn_limit | input | CNT_W | Programmable error warning limit |
| buf_wr | input | 1 | CPU write attempt to the transmit buffer |
| status | output | 8 | Read-only status word |
| tx_irq | output | 1 | Transmit interrupt pulse |
| eng_go | output | 1 | Request waiting for the engine |
| buf_we | output | 1 | Gated transmit buffer write enable |

## Verification
Two pairs of events can land in the same cycle: an abort with a request in one command write, and an abort with a frame start or retry strobe. The bench provokes both by driving them on the same clock. It then judges the winner from the status word and eng_go on the following cycle: nothing accepted, abort held until the retry point, or buffer released with bit 3 low. The warning comparison is swept over every counter and limit value at a 4-bit counter width.

// File: rtl/can_txctl_pkg.sv
package can_txctl_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_PEND = 2'd1,
        TX_XMIT = 2'd2
    } tx_state_e;

    typedef struct packed {
        tx_state_e st;
        logic      abort_held;
        logic      tcs;
        logic      irq;
    } txc_fsm_t;

    typedef struct packed {
        logic bo;
        logic es;
        logic rx;
    } txc_samp_t;

    localparam int unsigned STATUS_W = 8;

endpackage

// File: rtl/txc_req_fsm.sv
module txc_req_fsm
    import can_txctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_wr,
    input  logic      cmd_req,
    input  logic      cmd_abort,
    input  logic      eng_start,
    input  logic      eng_done,
    input  logic      eng_retry,
    input  logic      bus_off,
    output tx_state_e state,
    output logic      tcs,
    output logic      irq,
    output logic      go
);

    txc_fsm_t fsm_d, fsm_q;
    logic     accept;
    logic     abort_cmd;

    assign accept    = cmd_wr && cmd_req && !cmd_abort;
    assign abort_cmd = cmd_wr && cmd_abort;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.irq = 1'b0;
        if (bus_off) begin
            fsm_d.st         = TX_IDLE;
            fsm_d.abort_held = 1'b0;
        end else begin
            case (fsm_q.st)
                TX_IDLE: begin
                    if (accept) begin
                        fsm_d.st  = TX_PEND;
                        fsm_d.tcs = 1'b0;
                    end
                end
                TX_PEND: begin
                    if (eng_start) begin
                        fsm_d.st         = TX_XMIT;
                        fsm_d.abort_held = abort_cmd;
                    end else if (abort_cmd) begin
                        fsm_d.st = TX_IDLE;
                    end
                end
                TX_XMIT: begin
                    if (abort_cmd) begin
                        fsm_d.abort_held = 1'b1;
                    end
                    if (eng_done) begin
                        fsm_d.st         = TX_IDLE;
                        fsm_d.tcs        = 1'b1;
                        fsm_d.abort_held = 1'b0;
                    end else if (eng_retry) begin
                        fsm_d.abort_held = 1'b0;
                        fsm_d.st = (fsm_q.abort_held || abort_cmd) ? TX_IDLE : TX_PEND;
                    end
                end
                default: begin
                    fsm_d.st = TX_IDLE;
                end
            endcase
        end
        fsm_d.irq = (fsm_q.st != TX_IDLE) && (fsm_d.st == TX_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: TX_IDLE, abort_held: 1'b0, tcs: 1'b1, irq: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.st;
    assign tcs   = fsm_q.tcs;
    assign irq   = fsm_q.irq;
    assign go    = (fsm_q.st == TX_PEND) && !bus_off;

    AST_REQ_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fsm_q.st == TX_IDLE && !bus_off) |=> (fsm_q.st == TX_PEND && !fsm_q.tcs)); // R2

    AST_NO_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == TX_PEND && cmd_wr && !cmd_req && !cmd_abort && !eng_start && !bus_off)
        |=> (fsm_q.st == TX_PEND)); // R3

    AST_ABORT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == TX_PEND && abort_cmd && !eng_start && !bus_off)
        |=> (fsm_q.st == TX_IDLE && !fsm_q.tcs)); // R4

    AST_HELD_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == TX_XMIT && fsm_q.abort_held && eng_retry && !eng_done && !bus_off)
        |=> (fsm_q.st == TX_IDLE && !fsm_q.tcs)); // R7

    AST_BUSOFF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |=> (fsm_q.st == TX_IDLE)); // R12

endmodule

// File: rtl/txc_warn_cmp.sv
module txc_warn_cmp #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned N_CNT = 2
) (
    input  logic [N_CNT-1:0][CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0]            limit,
    output logic                        warn
);

    logic [N_CNT-1:0] hit;

    for (genvar i = 0; i < N_CNT; i++) begin : g_cmp
        assign hit[i] = (cnt[i] >= limit);
    end

    assign warn = |hit;

endmodule

// File: rtl/txc_status.sv
module txc_status
    import can_txctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_off,
    input  logic                warn,
    input  logic                rx_active,
    input  tx_state_e           state,
    input  logic                tcs,
    input  logic                irq,
    input  logic                buf_wr,
    output logic [STATUS_W-1:0] status,
    output logic                buf_we
);

    txc_samp_t samp_d, samp_q;
    logic      released;
    logic      sending;

    always_comb begin
        samp_d    = samp_q;
        samp_d.bo = bus_off;
        samp_d.es = warn;
        samp_d.rx = rx_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign released = (state == TX_IDLE);
    assign sending  = (state == TX_XMIT);
    assign status   = {samp_q.bo, samp_q.es, sending, samp_q.rx, tcs, released, 2'b00};
    assign buf_we   = buf_wr && released;

    AST_BUF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> status[2]); // R13

    AST_IRQ_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[2] && !$past(status[2]))); // R9

    AST_SEND_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] |-> !status[2]); // R6

endmodule

// File: rtl/can_txctl.sv
module can_txctl
    import can_txctl_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic                cmd_req,
    input  logic                cmd_abort,
    input  logic                eng_start,
    input  logic                eng_done,
    input  logic                eng_retry,
    input  logic                rx_active,
    input  logic                bus_off,
    input  logic [CNT_W-1:0]    tx_err_cnt,
    input  logic [CNT_W-1:0]    rx_err_cnt,
    input  logic [CNT_W-1:0]    warn_limit,
    input  logic                buf_wr,
    output logic [STATUS_W-1:0] status,
    output logic                tx_irq,
    output logic                eng_go,
    output logic                buf_we
);

    localparam int unsigned N_CNT = 2;

    tx_state_e                   state;
    logic                        tcs;
    logic                        warn;
    logic [N_CNT-1:0][CNT_W-1:0] cnts;

    assign cnts = {rx_err_cnt, tx_err_cnt};

    txc_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_req   (cmd_req),
        .cmd_abort (cmd_abort),
        .eng_start (eng_start),
        .eng_done  (eng_done),
        .eng_retry (eng_retry),
        .bus_off   (bus_off),
        .state     (state),
        .tcs       (tcs),
        .irq       (tx_irq),
        .go        (eng_go)
    );

    txc_warn_cmp #(
        .CNT_W (CNT_W),
        .N_CNT (N_CNT)
    ) u_warn (
        .cnt   (cnts),
        .limit (warn_limit),
        .warn  (warn)
    );

    txc_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_off   (bus_off),
        .warn      (warn),
        .rx_active (rx_active),
        .state     (state),
        .tcs       (tcs),
        .irq       (tx_irq),
        .buf_wr    (buf_wr),
        .status    (status),
        .buf_we    (buf_we)
    );

endmodule

// File: tb/can_txctl_bench.sv
`timescale 1ns/100ps
module can_txctl_bench;

    localparam int unsigned CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 0, cmd_req = 0, cmd_abort = 0;
    logic          eng_start = 0, eng_done = 0, eng_retry = 0;
    logic          rx_active = 0, bus_off = 0, buf_wr = 0;
    logic [CW-1:0] tx_err_cnt = '0, rx_err_cnt = '0, warn_limit = 4'd8;
    logic [7:0]    status;
    logic          tx_irq, eng_go, buf_we;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    can_txctl #(.CNT_W(CW)) u_can_txctl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_req(cmd_req), .cmd_abort(cmd_abort),
        .eng_start(eng_start), .eng_done(eng_done), .eng_retry(eng_retry),
        .rx_active(rx_active), .bus_off(bus_off), .tx_err_cnt(tx_err_cnt),
        .rx_err_cnt(rx_err_cnt), .warn_limit(warn_limit), .buf_wr(buf_wr),
        .status(status), .tx_irq(tx_irq), .eng_go(eng_go), .buf_we(buf_we)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cmd(input logic req, input logic ab);
        cmd_wr = 1; cmd_req = req; cmd_abort = ab;
        tick();
        cmd_wr = 0; cmd_req = 0; cmd_abort = 0;
    endtask

    task automatic strobe(input logic s, input logic d, input logic r, input logic ab);
        eng_start = s; eng_done = d; eng_retry = r;
        cmd_wr = ab; cmd_abort = ab;
        tick();
        eng_start = 0; eng_done = 0; eng_retry = 0; cmd_wr = 0; cmd_abort = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(); tick();
        chk("R1 status", status, 8'h0C);
        chk("R1 irq/go", {tx_irq, eng_go}, 8'h00);
        rst_n = 1;
        tick();
        chk("R1 after release", status, 8'h0C);

        buf_wr = 1; #0.5;
        chk("R13 released gate", {7'b0, buf_we}, 8'h01);

        cmd(1, 0);
        chk("R2 locked", status, 8'h00);
        chk("R2 go", {7'b0, eng_go}, 8'h01);
        chk("R13 locked gate", {7'b0, buf_we}, 8'h00);
        buf_wr = 0;

        cmd(0, 0);
        chk("R3 no withdraw", {status, 7'b0, eng_go} == 16'h0001 ? 8'h1 : 8'h0, 8'h1);

        cmd(0, 1);
        chk("R4 released", status, 8'h04);
        chk("R4 go", {7'b0, eng_go}, 8'h00);
        chk("R9 irq on abort", {7'b0, tx_irq}, 8'h01);
        tick();
        chk("R9 single pulse", {7'b0, tx_irq}, 8'h00);

        cmd(1, 1);
        chk("R5 req+abort", status, 8'h04);
        chk("R5 go", {7'b0, eng_go}, 8'h00);

        cmd(1, 0);
        strobe(1, 0, 0, 0);
        chk("R6 sending", status, 8'h20);
        chk("R6 go low", {7'b0, eng_go}, 8'h00);
        strobe(0, 1, 0, 0);
        chk("R6 done", status, 8'h0C);
        chk("R9 irq on done", {7'b0, tx_irq}, 8'h01);
        tick();
        chk("R9 pulse ends", {7'b0, tx_irq}, 8'h00);

        cmd(1, 0);
        strobe(1, 0, 0, 0);
        strobe(0, 0, 1, 0);
        chk("R8 retry waits", status, 8'h00);
        chk("R8 go", {7'b0, eng_go}, 8'h01);
        strobe(1, 0, 0, 1);
        chk("R7 abort held, still sending", status, 8'h20);
        strobe(0, 1, 0, 0);
        chk("R7 held abort, frame completes", status, 8'h0C);

        cmd(1, 0);
        strobe(1, 0, 0, 0);
        strobe(0, 0, 0, 1);
        chk("R7 abort mid-frame", status, 8'h20);
        strobe(0, 0, 1, 0);
        chk("R7 retry suppressed", status, 8'h04);
        chk("R7 go", {6'b0, eng_go, tx_irq}, 8'h01);

        cmd(1, 0);
        strobe(1, 0, 0, 0);
        bus_off = 1;
        tick();
        chk("R12 bus-off drop", status, 8'h84);
        chk("R12 irq", {6'b0, eng_go, tx_irq}, 8'h01);
        cmd(1, 0);
        chk("R12 req ignored", status, 8'h84);
        chk("R12 go", {7'b0, eng_go}, 8'h00);
        bus_off = 0;
        rx_active = 1;
        tick();
        chk("R11 rx bit", status, 8'h14);
        rx_active = 0;
        tick();
        chk("R11 low bits", {6'b0, status[1:0]}, 8'h00);

        for (int l = 0; l < 16; l++) begin
            for (int t = 0; t < 16; t++) begin
                for (int r = 0; r < 16; r++) begin
                    warn_limit = l[CW-1:0];
                    tx_err_cnt = t[CW-1:0];
                    rx_err_cnt = r[CW-1:0];
                    tick();
                    chk("R10 warn", {7'b0, status[6]}, ((t >= l) || (r >= l)) ? 8'h01 : 8'h00);
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule